// File: doc/BRIEF.md
# Digital PWM With Averaging Sample Strobes

This block turns a duty command into the main switching signal of a multilevel boost front end. A free-running counter sets the switching period. The output is high for the first `duty` clocks of each period. The same counter also places four one-clock strobes that start conversions and trigger sample-and-hold circuits outside the block.

The inductor-current strobe falls at the middle of the longer of the two switching intervals. A sample taken there equals the average current over the cycle, and it sits well away from both edges, where switching noise is worst.

The two capacitor strobes depend on which switching state the converter is in. A 2-bit operating-band code tells the block whether the second transistor conducts while the PWM output is high or while it is low. The top-capacitor strobe is placed in the middle of the interval where that transistor conducts. The bottom-capacitor strobe and the bus-ADC start are placed in the middle of the other interval, where the second diode conducts. Each measured node therefore shares the controller ground at the moment it is sampled.

The duty command and the band code are both taken only at the period boundary.

Top module: `pwm_strobe_gen`

## Requirements
- R1: While reset is asserted, all five outputs are low. The first switching period starts at the first rising clock edge after reset is released and runs with duty 0 and band 1. Outputs are registered: the output for position p of a period appears after rising edge k, where p = (k-1) mod PERIOD.
- R2: The switching period is PERIOD clocks long. Let d = min(duty, PERIOD). The PWM output is high at positions 0..d-1 and low at all other positions.
- R3: The duty word and the band code are captured only at the last position of a period, and they take effect from position 0 of the next period. A change to either input at any other time has no effect on the outputs in the current period.
- R4: With d = 0 the PWM output stays low for the whole period. Any duty word of PERIOD or above gives a PWM output that stays high for the whole period, with no edge inside the period.
- R5: The current strobe is high for exactly one clock in every period. When 2d >= PERIOD it falls at position floor(d/2). Otherwise it falls at position d + floor((PERIOD-d)/2).
- R6: Band code 2 means the second transistor conducts while the PWM output is low. Codes 0, 1 and 3 all mean it conducts while the PWM output is high.
- R7: The top-capacitor strobe is high for one clock, at the midpoint of the interval in which the second transistor conducts. For the high interval that is position floor(d/2). For the low interval it is d + floor((PERIOD-d)/2). If that interval is empty, the strobe is absent for the period.
- R8: The bottom-capacitor strobe is high for one clock, at the midpoint of the complementary interval, where the second diode conducts. If that interval is empty, the strobe is absent. It is never high in the same clock as the top-capacitor strobe.
- R9: The bus-ADC start strobe is high in exactly the clocks in which the bottom-capacitor strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_i | input | CNT_W | Duty command in clocks, captured at the period boundary |
| band_i | input | 2 | Operating-band code, captured at the period boundary |
| pwm_o | output | 1 | Main switching signal |
| isense_start_o | output | 1 | Inductor-current ADC start strobe |
| vtop_sample_o | output | 1 | Top-capacitor sample strobe |
| vbot_sample_o | output | 1 | Bottom-capacitor sample strobe |
| vbus_start_o | output | 1 | Bus-voltage ADC start strobe |

## Verification
The bench builds the block with PERIOD = 10, which gives a 4-bit counter. At that size every legal duty value from 0 to 10, two over-range codes (11 and 12), and all four band codes fit into 52 consecutive periods. Every clock of every period is compared against positions computed arithmetically in the bench. This covers odd and even interval lengths, so both ways the midpoint can round are exercised. It also covers the switch-over between the on-midpoint and off-midpoint rules for the current strobe at d = 5, and the empty intervals at both ends of the duty range. New commands are driven in the middle of each period, so every period also shows that a command arriving mid-period is held off until the boundary.

// File: rtl/pwm_strobe_pkg.sv
package pwm_strobe_pkg;

    // Operating band: tells where the second transistor conducts
    typedef enum logic [1:0] {
        BAND_SPARE = 2'd0,
        BAND_LOW   = 2'd1,
        BAND_MID   = 2'd2,
        BAND_HIGH  = 2'd3
    } band_e;

    typedef struct packed {
        logic pwm;
        logic isense;
        logic vtop;
        logic vbot;
        logic vbus;
    } strobe_t;

    // True when the second transistor conducts during the PWM-high interval
    function automatic logic sw2_in_high(input band_e b);
        return (b != BAND_MID);
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_strobe_pkg::*;
#(
    parameter int PERIOD = 1250,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [1:0]       band_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] duty_o,
    output band_e            band_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] duty;
        band_e            band;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      last;

    always_comb begin
        st_d = st_q;
        last = (st_q.cnt == LAST);
        if (last) begin
            st_d.cnt  = '0;
            st_d.duty = (duty_i > FULL) ? FULL : duty_i;
            st_d.band = band_e'(band_i);
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.duty <= '0;
            st_q.band <= BAND_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign duty_o = st_q.duty;
    assign band_o = st_q.band;
    assign last_o = last;

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> ($stable(st_q.duty) && $stable(st_q.band)));

    assert_duty_clamped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.duty <= FULL);

endmodule

// File: rtl/pwm_midpoints.sv
module pwm_midpoints #(
    parameter int PERIOD = 1250,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic [CNT_W-1:0] duty_i,
    output logic [CNT_W-1:0] on_mid_o,
    output logic [CNT_W-1:0] off_mid_o,
    output logic             on_ok_o,
    output logic             off_ok_o,
    output logic [CNT_W-1:0] isense_pos_o
);

    localparam int               EXT_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(PERIOD);

    logic [CNT_W-1:0] off_len;
    logic             on_longer;

    always_comb begin
        off_len      = FULL - duty_i;
        on_mid_o     = duty_i >> 1;
        off_mid_o    = duty_i + (off_len >> 1);
        on_ok_o      = (duty_i != '0);
        off_ok_o     = (duty_i != FULL);
        on_longer    = ({duty_i, 1'b0} >= EXT_W'(PERIOD));
        isense_pos_o = on_longer ? on_mid_o : off_mid_o;
    end

endmodule

// File: rtl/pwm_strobe_gen.sv
module pwm_strobe_gen
    import pwm_strobe_pkg::*;
#(
    parameter int PERIOD = 1250,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [1:0]       band_i,
    output logic             pwm_o,
    output logic             isense_start_o,
    output logic             vtop_sample_o,
    output logic             vbot_sample_o,
    output logic             vbus_start_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(PERIOD);

    logic [CNT_W-1:0] cnt, duty, on_mid, off_mid, isense_pos;
    logic             on_ok, off_ok, last;
    band_e            band;

    pwm_timebase #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty_i (duty_i),
        .band_i (band_i),
        .cnt_o  (cnt),
        .duty_o (duty),
        .band_o (band),
        .last_o (last)
    );

    pwm_midpoints #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_midpoints (
        .duty_i       (duty),
        .on_mid_o     (on_mid),
        .off_mid_o    (off_mid),
        .on_ok_o      (on_ok),
        .off_ok_o     (off_ok),
        .isense_pos_o (isense_pos)
    );

    typedef struct packed {
        strobe_t    out;
        logic [1:0] seen;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       on_hit, off_hit;

    always_comb begin
        st_d           = st_q;
        on_hit         = on_ok  && (cnt == on_mid);
        off_hit        = off_ok && (cnt == off_mid);
        st_d.out.pwm    = (cnt < duty);
        st_d.out.isense = (cnt == isense_pos);
        if (sw2_in_high(band)) begin
            st_d.out.vtop = on_hit;
            st_d.out.vbot = off_hit;
        end else begin
            st_d.out.vtop = off_hit;
            st_d.out.vbot = on_hit;
        end
        st_d.out.vbus = st_d.out.vbot;
        if (last) begin
            st_d.seen = '0;
        end else if (st_q.seen != 2'd3) begin
            st_d.seen = st_q.seen + {1'b0, st_d.out.isense};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o          = st_q.out.pwm;
    assign isense_start_o = st_q.out.isense;
    assign vtop_sample_o  = st_q.out.vtop;
    assign vbot_sample_o  = st_q.out.vbot;
    assign vbus_start_o   = st_q.out.vbus;

    assert_isense_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> (({1'b0, st_q.seen} + {2'b00, st_d.out.isense}) == 3'd1));

    assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(duty) == '0) |-> !st_q.out.pwm);

    assert_full_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(duty) == FULL) |-> st_q.out.pwm);

    assert_top_in_sw2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.out.vtop |-> (st_q.out.pwm == sw2_in_high($past(band))));

    assert_bot_in_diode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.out.vbot |-> (st_q.out.pwm != sw2_in_high($past(band))));

    assert_cap_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.out.vtop && st_q.out.vbot));

endmodule

// File: tb/pwm_strobe_gen_test.sv
module pwm_strobe_gen_test;

    localparam int P = 10;
    localparam int W = 4;
    localparam int NPER = 52;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] duty = '0;
    logic [1:0]   band = 2'd1;
    logic         pwm, isense, vtop, vbot, vbus;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    pwm_strobe_gen #(.PERIOD(P), .CNT_W(W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .duty_i         (duty),
        .band_i         (band),
        .pwm_o          (pwm),
        .isense_start_o (isense),
        .vtop_sample_o  (vtop),
        .vbot_sample_o  (vbot),
        .vbus_start_o   (vbus)
    );

    task automatic check(input string req, input string what, input int per,
                         input int pos, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s period %0d pos %0d: actual %0b expected %0b",
                     req, what, per, pos, act, exp);
        end
    endtask

    function automatic int next_duty(input int j);
        return (j - 1) % 13;
    endfunction

    function automatic int next_band(input int j);
        return ((j - 1) / 13) % 4;
    endfunction

    initial begin
        int cur_duty = 0;
        int cur_band = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: all outputs low under reset
        check("R1", "pwm reset", 0, 0, pwm, 1'b0);
        check("R1", "isense reset", 0, 0, isense, 1'b0);
        check("R1", "vtop reset", 0, 0, vtop, 1'b0);
        check("R1", "vbot reset", 0, 0, vbot, 1'b0);
        check("R1", "vbus reset", 0, 0, vbus, 1'b0);
        rst_n = 1'b1;
        for (int j = 0; j <= NPER; j++) begin
            int d, on_mid, off_mid, ipos;
            bit hi_sw2;
            int n_is;
            d       = (cur_duty > P) ? P : cur_duty;
            on_mid  = d / 2;
            off_mid = d + (P - d) / 2;
            ipos    = (2 * d >= P) ? on_mid : off_mid;
            hi_sw2  = (cur_band != 2);
            n_is    = 0;
            for (int pos = 0; pos < P; pos++) begin
                bit on_hit, off_hit, e_top, e_bot;
                @(posedge clk);
                @(negedge clk);
                on_hit  = (d > 0) && (pos == on_mid);
                off_hit = (d < P) && (pos == off_mid);
                e_top   = hi_sw2 ? on_hit : off_hit;
                e_bot   = hi_sw2 ? off_hit : on_hit;
                if (d == 0 || d == P)
                    check("R4", "pwm level", j, pos, pwm, pos < d);
                else
                    check("R2 R3", "pwm", j, pos, pwm, pos < d);
                check("R5", "isense", j, pos, isense, pos == ipos);
                check("R6 R7", "vtop", j, pos, vtop, e_top);
                check("R8", "vbot", j, pos, vbot, e_bot);
                check("R9", "vbus", j, pos, vbus, e_bot);
                if (isense) n_is++;
                if (pos == P / 2 && j < NPER) begin
                    duty = W'(next_duty(j + 1));
                    band = 2'(next_band(j + 1));
                end
            end
            check("R5", "isense count", j, P, n_is == 1, 1'b1);
            if (j < NPER) begin
                cur_duty = next_duty(j + 1);
                cur_band = next_band(j + 1);
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule